// File: doc/BRIEF.md
# Multichannel Folded Wavelet Decomposition Engine

This block takes signed samples from several neural recording channels, interleaved on one input stream, and produces a three-level one-dimensional discrete wavelet decomposition of each channel. It uses the 4-tap Daubechies filter pair. Every coefficient it emits is tagged with its channel, its decomposition level, and whether it is a detail or an approximation value. All channels and all three levels share a single 4-tap multiply-accumulate datapath. Each channel keeps its own short history of samples for every level, so the channels never affect one another.

Each sample that enters a level is shifted into that level's history. On every second sample of a level (the odd phase of a sample pair), the datapath runs twice. The first pass uses the high-pass taps and emits a detail coefficient. The second pass uses the low-pass taps and produces an approximation. For levels 1 and 2, this approximation is passed straight back into the same datapath as the next sample of the level below it in the cascade. At level 3 it is emitted. The scheduler chains these passes one per cycle, so a sample that completes pairs at every level keeps the datapath busy for six cycles in a row. The input handshake stalls until the chain has finished.

The coefficients are produced in the polyphase sense: output n of a level depends on that level's inputs 2n+1, 2n, 2n−1 and 2n−2. Inputs before the first sample count as zero.

Top module: `wvlt_mc_engine`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0, and every channel's history at every level reads as zero. The first coefficients of a level are therefore computed with zero padding in place of samples that never arrived.
- R2: The low-pass taps are h = (989, 1713, 459, −265) and the high-pass taps are g = (−265, −459, 1713, −989), both scaled by 2^11. For level-1 output n of a channel, detail = Σ g[k]·x[2n+1−k] and approximation = Σ h[k]·x[2n+1−k], where x is that channel's input sequence counted from 0.
- R3: A level emits one detail coefficient for every two samples that enter it. A level-1 input count of S per channel therefore yields ⌊S/2⌋, ⌊S/4⌋ and ⌊S/8⌋ details at levels 1, 2 and 3.
- R4: The approximation sequence of level j is the input sequence of level j+1, using the same formula as R2. Only level 3 emits approximation beats.
- R5: When a pair completes, the beats appear in this order: the detail of that level, then (if the pair fed a completing pair below it) the next level's detail. A level-3 detail is followed in the very next cycle by the level-3 approximation. After a level-1 or level-2 detail there is one cycle with no output.
- R6: Each channel's coefficients depend only on that channel's own samples, whatever order the channels arrive in.
- R7: One sample is accepted on a cycle where both `in_valid` and `in_ready` are 1. `in_ready` is 0 from the following cycle until all processing for that sample is done, and no beat is emitted while `in_ready` is 1.
- R8: Each coefficient is ⌊acc/2^11 + 1/2⌋ of the exact integer sum, delivered as 16-bit two's complement. Full-scale 10-bit input patterns at every level give correct values without wrap-around.
- R9: `out_ch` equals the channel of the sample being processed. `out_level` is encoded 1, 2 or 3. `out_is_detail` is 1 for a detail beat and 0 for an approximation beat.
- R10: After an accept, `in_ready` stays low for 1 cycle if level 1 was in its even phase. If the chain stops storing an even-phase sample at level k, it stays low for 2k−1 cycles. If the chain completes level 3, it stays low for 6 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Engine can take a sample this cycle |
| in_ch | input | CHW = clog2(N_CH) | Channel of the input sample |
| in_sample | input | IN_W (10) | Signed input sample |
| out_valid | output | 1 | Coefficient beat present |
| out_ch | output | CHW | Channel of the coefficient |
| out_level | output | 2 | Decomposition level, 1 to 3 |
| out_is_detail | output | 1 | 1 = detail, 0 = approximation |
| out_coef | output | 16 | Signed rounded coefficient |

## Verification
The bench builds the engine with N_CH = 4. This keeps a full round-robin sweep short enough to cover every channel with a distinct pattern: a positive impulse on the even phase, a negative impulse on the odd phase, random values, and a full-scale sign pattern. It then adds a long stretch of random channel order. With four channels, each history reaches all three levels many times over. This exercises every phase combination of the cascade, and therefore every stall length, as well as the zero-padded start of each level. A bench reference model rebuilds the taps from their closed form, computes every coefficient in real arithmetic with the same rounding, and compares each beat and each stall length.

// File: rtl/wvlt_pkg.sv
package wvlt_pkg;

    localparam int SW     = 16;              // sample / coefficient width on all levels
    localparam int COEF_W = 12;              // tap width
    localparam int FRAC   = 11;              // tap fraction bits
    localparam int NTAP   = 4;               // taps per filter
    localparam int NLVL   = 3;               // decomposition levels
    localparam int HIST   = NTAP - 1;        // stored past samples per level
    localparam int ACC_W  = SW + COEF_W + 2; // exact sum of NTAP products

    typedef logic signed [SW-1:0] smp_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_EVAL   = 2'd1,
        ST_APPROX = 2'd2
    } state_e;

    // Tap k of the low-pass (hp = 0) or high-pass (hp = 1) filter.
    // High-pass is the quadrature mirror: reversed order, odd taps negated.
    function automatic logic signed [COEF_W-1:0] tap_of(input logic hp, input int k);
        logic signed [COEF_W-1:0] r;
        int j;
        j = hp ? (NTAP - 1 - k) : k;
        case (j)
            0:       r = COEF_W'(989);
            1:       r = COEF_W'(1713);
            2:       r = COEF_W'(459);
            default: r = COEF_W'(-265);
        endcase
        if (hp && (k % 2 == 1)) r = -r;
        return r;
    endfunction

endpackage

// File: rtl/wvlt_fir4.sv
module wvlt_fir4
    import wvlt_pkg::*;
(
    input  logic              sel_hp,
    input  logic signed [SW-1:0] x [NTAP],
    output logic signed [SW-1:0] y
);

    localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) <<< (FRAC - 1);

    logic signed [ACC_W-1:0] prod [NTAP];

    for (genvar k = 0; k < NTAP; k++) begin : g_tap
        logic signed [ACC_W-1:0] xe;
        logic signed [ACC_W-1:0] te;
        always_comb begin
            xe      = ACC_W'(x[k]);
            te      = ACC_W'(tap_of(sel_hp, k));
            prod[k] = xe * te;
        end
    end

    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] scaled;

    always_comb begin
        acc = '0;
        for (int k = 0; k < NTAP; k++) begin
            acc = acc + prod[k];
        end
        scaled = (acc + HALF) >>> FRAC;
        y      = scaled[SW-1:0];
    end

endmodule

// File: rtl/wvlt_hist_bank.sv
module wvlt_hist_bank
    import wvlt_pkg::*;
#(
    parameter int N_CH = 8,
    parameter int CHW  = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CHW-1:0]       ch,
    input  logic [1:0]           lvl_idx,
    output logic [HIST-1:0][SW-1:0] hist_o,
    output logic                 phase_o,
    input  logic                 wr_en,
    input  logic [SW-1:0]        wr_sample
);

    logic [SW-1:0] line_q [N_CH][NLVL][HIST];
    logic          odd_q  [N_CH][NLVL];

    logic [1:0] li;

    always_comb begin
        li = (lvl_idx < 2'(NLVL)) ? lvl_idx : 2'd0;
        for (int t = 0; t < HIST; t++) begin
            hist_o[t] = line_q[ch][li][t];
        end
        phase_o = odd_q[ch][li];
    end

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        for (genvar l = 0; l < NLVL; l++) begin : g_lvl
            logic hit;
            assign hit = wr_en && (ch == CHW'(c)) && (li == 2'(l));
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int t = 0; t < HIST; t++) begin
                        line_q[c][l][t] <= '0;
                    end
                    odd_q[c][l] <= 1'b0;
                end else if (hit) begin
                    line_q[c][l][0] <= wr_sample;
                    for (int t = 1; t < HIST; t++) begin
                        line_q[c][l][t] <= line_q[c][l][t-1];
                    end
                    odd_q[c][l] <= ~odd_q[c][l];
                end
            end
        end
    end

endmodule

// File: rtl/wvlt_mc_engine.sv
module wvlt_mc_engine
    import wvlt_pkg::*;
#(
    parameter  int N_CH = 8,
    parameter  int IN_W = 10,
    localparam int CHW  = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [CHW-1:0]       in_ch,
    input  logic signed [IN_W-1:0] in_sample,
    output logic                 out_valid,
    output logic [CHW-1:0]       out_ch,
    output logic [1:0]           out_level,
    output logic                 out_is_detail,
    output logic signed [SW-1:0] out_coef
);

    typedef struct packed {
        state_e         st;
        logic [CHW-1:0] ch;
        logic [1:0]     lvl;
        smp_t           smp;
    } job_t;

    job_t job_q, job_d;

    logic [1:0]               lvl_idx;
    logic [HIST-1:0][SW-1:0]  hist;
    logic                     odd_phase;
    logic                     wr_en;
    logic                     sel_hp;
    logic signed [SW-1:0]     fir_x [NTAP];
    logic signed [SW-1:0]     fir_y;

    always_comb begin
        lvl_idx  = job_q.lvl - 2'd1;
        fir_x[0] = job_q.smp;
        for (int t = 1; t < NTAP; t++) begin
            fir_x[t] = hist[t-1];
        end
    end

    wvlt_hist_bank #(
        .N_CH (N_CH),
        .CHW  (CHW)
    ) u_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .ch        (job_q.ch),
        .lvl_idx   (lvl_idx),
        .hist_o    (hist),
        .phase_o   (odd_phase),
        .wr_en     (wr_en),
        .wr_sample (job_q.smp)
    );

    wvlt_fir4 u_fir (
        .sel_hp (sel_hp),
        .x      (fir_x),
        .y      (fir_y)
    );

    always_comb begin
        job_d         = job_q;
        wr_en         = 1'b0;
        sel_hp        = (job_q.st == ST_EVAL);
        in_ready      = (job_q.st == ST_IDLE);
        out_valid     = 1'b0;
        out_ch        = job_q.ch;
        out_level     = job_q.lvl;
        out_is_detail = (job_q.st == ST_EVAL);
        out_coef      = fir_y;

        case (job_q.st)
            ST_IDLE: begin
                if (in_valid) begin
                    job_d.st  = ST_EVAL;
                    job_d.ch  = in_ch;
                    job_d.lvl = 2'd1;
                    job_d.smp = SW'(in_sample);
                end
            end
            ST_EVAL: begin
                if (!odd_phase) begin
                    wr_en    = 1'b1;
                    job_d.st = ST_IDLE;
                end else begin
                    out_valid = 1'b1;
                    job_d.st  = ST_APPROX;
                end
            end
            ST_APPROX: begin
                wr_en = 1'b1;
                if (job_q.lvl == 2'(NLVL)) begin
                    out_valid = 1'b1;
                    job_d.st  = ST_IDLE;
                end else begin
                    job_d.smp = fir_y;
                    job_d.lvl = job_q.lvl + 2'd1;
                    job_d.st  = ST_EVAL;
                end
            end
            default: job_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            job_q <= '0;
        end else begin
            job_q <= job_d;
        end
    end

endmodule

// File: rtl/wvlt_mc_engine_chk.sv
module wvlt_mc_engine_chk
    import wvlt_pkg::*;
#(
    parameter  int N_CH = 8,
    parameter  int IN_W = 10,
    localparam int CHW  = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic                 in_ready,
    input logic [CHW-1:0]       in_ch,
    input logic signed [IN_W-1:0] in_sample,
    input logic                 out_valid,
    input logic [CHW-1:0]       out_ch,
    input logic [1:0]           out_level,
    input logic                 out_is_detail,
    input logic signed [SW-1:0] out_coef
);

    logic [CHW-1:0] last_ch_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_ch_q <= '0;
        end else if (in_valid && in_ready) begin
            last_ch_q <= in_ch;
        end
    end

    p_level_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_level >= 2'd1 && out_level <= 2'd3));

    p_tag_channel_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_ch == last_ch_q));

    p_approx_final_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_is_detail) |-> (out_level == 2'd3));

    p_accept_stalls_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    p_no_beat_when_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    p_last_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_is_detail && out_level == 2'd3)
        |=> (out_valid && !out_is_detail && out_level == 2'd3));

    p_gap_after_detail_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_is_detail && out_level != 2'd3) |=> !out_valid);

endmodule

bind wvlt_mc_engine wvlt_mc_engine_chk #(
    .N_CH (N_CH),
    .IN_W (IN_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .in_ch         (in_ch),
    .in_sample     (in_sample),
    .out_valid     (out_valid),
    .out_ch        (out_ch),
    .out_level     (out_level),
    .out_is_detail (out_is_detail),
    .out_coef      (out_coef)
);

// File: tb/wvlt_mc_engine_test.sv
module wvlt_mc_engine_test;

    localparam int NC  = 4;
    localparam int CW  = 2;
    localparam int IW  = 10;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic                 in_ready;
    logic [CW-1:0]        in_ch = '0;
    logic signed [IW-1:0] in_sample = '0;
    logic                 out_valid;
    logic [CW-1:0]        out_ch;
    logic [1:0]           out_level;
    logic                 out_is_detail;
    logic signed [15:0]   out_coef;

    always #10 clk = ~clk;   // 50 MHz

    wvlt_mc_engine #(.N_CH(NC), .IN_W(IW)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .in_ready      (in_ready),
        .in_ch         (in_ch),
        .in_sample     (in_sample),
        .out_valid     (out_valid),
        .out_ch        (out_ch),
        .out_level     (out_level),
        .out_is_detail (out_is_detail),
        .out_coef      (out_coef)
    );

    int n_checks = 0;
    int n_fail   = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    int  lp [4];
    int  hp [4];
    int  mh  [NC][3][3];
    bit  modd [NC][3];
    int  sent [NC];
    int  got_det [NC][3];
    bit  phase_b = 1'b0;

    int  e_ch[$];
    int  e_lvl[$];
    int  e_det[$];
    int  e_coef[$];

    function automatic int qtap(input real v);
        return $rtoi($floor(v * 2048.0 + 0.5));
    endfunction

    function automatic int filt(input bit use_hp, input int x0, input int x1, input int x2, input int x3);
        real acc;
        int  t [4];
        for (int k = 0; k < 4; k++) t[k] = use_hp ? hp[k] : lp[k];
        acc = real'(t[0]) * x0 + real'(t[1]) * x1 + real'(t[2]) * x2 + real'(t[3]) * x3;
        return $rtoi($floor(acc / 2048.0 + 0.5));
    endfunction

    function automatic int model_step(input int ch, input int x);
        int v;
        int busy;
        int d;
        int a;
        v    = x;
        busy = 0;
        for (int l = 0; l < 3; l++) begin
            busy++;
            if (!modd[ch][l]) begin
                mh[ch][l][2] = mh[ch][l][1];
                mh[ch][l][1] = mh[ch][l][0];
                mh[ch][l][0] = v;
                modd[ch][l]  = 1'b1;
                break;
            end
            d = filt(1'b1, v, mh[ch][l][0], mh[ch][l][1], mh[ch][l][2]);
            a = filt(1'b0, v, mh[ch][l][0], mh[ch][l][1], mh[ch][l][2]);
            e_ch.push_back(ch); e_lvl.push_back(l + 1); e_det.push_back(1); e_coef.push_back(d);
            busy++;
            mh[ch][l][2] = mh[ch][l][1];
            mh[ch][l][1] = mh[ch][l][0];
            mh[ch][l][0] = v;
            modd[ch][l]  = 1'b0;
            if (l == 2) begin
                e_ch.push_back(ch); e_lvl.push_back(3); e_det.push_back(0); e_coef.push_back(a);
                break;
            end
            v = a;
        end
        return busy;
    endfunction

    // ---------------- output monitor ----------------
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (e_coef.size() == 0) begin
                check(1'b0, "R4 unexpected beat", int'(out_level), 0);
            end else begin
                int xc;
                int xl;
                int xd;
                int xv;
                string tag;
                xc = e_ch.pop_front();
                xl = e_lvl.pop_front();
                xd = e_det.pop_front();
                xv = e_coef.pop_front();
                if (phase_b)      tag = "R6 coefficient";
                else if (xc == 3) tag = "R8 coefficient";
                else if (xl == 1) tag = "R2 coefficient";
                else              tag = "R4 coefficient";
                check(int'(out_coef) == xv, tag, int'(out_coef), xv);
                check(int'(out_ch) == xc, "R9 channel tag", int'(out_ch), xc);
                check(int'(out_level) == xl && int'(out_is_detail) == xd,
                      "R5 level/kind order", int'(out_level) * 2 + int'(out_is_detail), xl * 2 + xd);
                if (out_is_detail) got_det[int'(out_ch)][int'(out_level) - 1]++;
            end
        end
    end

    // ---------------- driver ----------------
    task automatic send(input int ch, input int x);
        int busy_exp;
        int low;
        busy_exp = model_step(ch, x);
        sent[ch]++;
        in_valid  = 1'b1;
        in_ch     = CW'(ch);
        in_sample = IW'(x);
        @(negedge clk);
        in_valid = 1'b0;
        low = 0;
        while (!in_ready && low < 50) begin
            low++;
            @(negedge clk);
        end
        check(low == busy_exp, "R10 stall length", low, busy_exp);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (120000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        real s3;
        real nrm;
        s3  = $sqrt(3.0);
        nrm = 4.0 * $sqrt(2.0);
        lp[0] = qtap((1.0 + s3) / nrm);
        lp[1] = qtap((3.0 + s3) / nrm);
        lp[2] = qtap((3.0 - s3) / nrm);
        lp[3] = qtap((1.0 - s3) / nrm);
        for (int k = 0; k < 4; k++) hp[k] = ((k % 2) ? -1 : 1) * lp[3 - k];
        for (int c = 0; c < NC; c++) begin
            sent[c] = 0;
            for (int l = 0; l < 3; l++) begin
                modd[c][l] = 1'b0;
                got_det[c][l] = 0;
                for (int t = 0; t < 3; t++) mh[c][l][t] = 0;
            end
        end

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
        check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
        // R7: no accept while in_valid low
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0 && in_ready == 1'b1, "R7 idle without in_valid",
              int'(out_valid), 0);

        // Phase A: round-robin, distinct pattern per channel (R1 zero padding, R2, R4, R8)
        for (int i = 0; i < 48; i++) begin
            for (int c = 0; c < NC; c++) begin
                int x;
                case (c)
                    0: x = (i == 0) ? 511 : 0;
                    1: x = (i == 1) ? -512 : 0;
                    2: x = int'($urandom_range(1023)) - 512;
                    default: x = ($urandom_range(1) != 0) ? 511 : -512;
                endcase
                send(c, x);
            end
        end

        // Phase B: random channel order (R6)
        phase_b = 1'b1;
        for (int i = 0; i < 320; i++) begin
            send(int'($urandom_range(NC - 1)), int'($urandom_range(1023)) - 512);
        end

        repeat (10) @(negedge clk);
        check(e_coef.size() == 0, "R4 missing beats", e_coef.size(), 0);
        for (int c = 0; c < NC; c++) begin
            check(got_det[c][0] == sent[c] / 2, "R3 level-1 details", got_det[c][0], sent[c] / 2);
            check(got_det[c][1] == sent[c] / 4, "R3 level-2 details", got_det[c][1], sent[c] / 4);
            check(got_det[c][2] == sent[c] / 8, "R3 level-3 details", got_det[c][2], sent[c] / 8);
        end
        finish_run();
    end

endmodule